// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Transmitter

This block serialises a stream of 16-bit stereo PCM sample pairs onto one wire as a consumer digital-audio line signal. Each frame carries a left subframe and then a right subframe. Each subframe has 32 slots: a 4-slot synchronisation preamble, 24 audio slots, and the validity, user, channel-status and parity slots. Every slot becomes two line cells. A cell-rate clock enable sets the pace, and each enable pulse puts exactly one cell on the line. The enable therefore has to run at 128 times the sample rate.

The upstream source offers one sample pair per frame with a valid/ready handshake. The pair is taken only at the start of a frame. If no pair is offered, the frame still goes out with all audio bits zero and the proper preambles. A mute input marks the audio as invalid by setting the validity slot. The parity slot is always sent as 0. A spare low-order audio slot is set so that even parity over slots 4..31 holds whatever the sample and mute state are. A frame counter marks the first frame of every 192-frame block with the block-start preamble.

Top module: `bmc_audio_tx`

## Requirements
- R1: After reset `line_out` is 0 and `smp_ready` is 1, and `line_out` does not change until the first cycle with `cell_tick` high.
- R2: Each clock edge with `cell_tick` high puts one new cell on `line_out`, which then holds until the next such edge. A frame is 128 cells: cells 0..63 are the left subframe and cells 64..127 are the right subframe.
- R3: A subframe begins with 8 preamble cells, sent first to last. The patterns are 11101000 (block start), 11100010 (left) and 11100100 (right). They apply when the line was 0 before the preamble and are inverted when it was 1.
- R4: The left subframe of the first frame after reset, and of every 192nd frame after it, uses the block-start preamble. Every other left subframe uses the left preamble. The right subframe always uses the right preamble.
- R5: Slots 4..31 (slot n occupies subframe cells 2n and 2n+1) are biphase-mark coded. The first cell of a slot is the inverse of the cell before it. The second cell inverts again for a 1 and repeats for a 0.
- R6: The sample is sent least significant bit first in slots 12..27. Slots 5..11 (filler), 29 (user) and 30 (channel status) are 0, and slot 31 (parity) is always 0.
- R7: Slot 4 is set so that the number of ones in slots 4..31 is even.
- R8: Slot 28 (validity) is 1 in both subframes of a frame for which mute was latched, and 0 otherwise.
- R9: A frame whose start saw `smp_valid` low carries zero in all audio slots of both subframes. It still has the correct preambles, validity and parity.
- R10: `smp_ready` is 1 exactly while the next cell due is cell 0 of a frame. Samples, `smp_valid` and `mute` are taken on the `cell_tick` edge that sends cell 0. Changes to them at any other time do not affect the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_tick | input | 1 | Cell-rate enable, one pulse per line cell |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | Next cell starts a frame; the pair is taken on the next tick |
| smp_left | input | 16 | Left PCM sample |
| smp_right | input | 16 | Right PCM sample |
| mute | input | 1 | Mark the frame's audio as invalid |
| line_out | output | 1 | Serial biphase-mark line |

## Verification
`line_out` shows a cell on the clock after the edge at which `cell_tick` was sampled high. The bench therefore samples the line at the falling edge that follows each tick and compares it with the next entry of a model queue filled before the frame starts. `smp_ready` is registered and rises after the tick that sends cell 127. The bench checks it at the falling edge before every tick. A sample pair or mute change first shows up on slot 4, eight ticks after the cell-0 tick. Values offered after that tick are modelled as having no effect until the following frame. Tick gaps of one idle cycle are mixed in, and the line is checked to hold during them.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int SLOTS       = 32;
  localparam int SUB_CELLS   = 2 * SLOTS;
  localparam int FRAME_CELLS = 2 * SUB_CELLS;
  localparam int CHANNELS    = 2;
  localparam int PRE_CELLS   = 8;

  // slot positions the line format fixes
  localparam int SLOT_BAL    = 4;
  localparam int SLOT_VALID  = 28;
  localparam int SLOT_PAR    = 31;

  typedef enum logic [1:0] {KIND_BLOCK, KIND_LEFT, KIND_RIGHT} pre_kind_e;

  // patterns for a line that was low, first cell in the MSB
  localparam logic [PRE_CELLS-1:0] PAT_BLOCK = 8'b1110_1000;
  localparam logic [PRE_CELLS-1:0] PAT_LEFT  = 8'b1110_0010;
  localparam logic [PRE_CELLS-1:0] PAT_RIGHT = 8'b1110_0100;

  function automatic logic [PRE_CELLS-1:0] pre_pattern(pre_kind_e k);
    case (k)
      KIND_BLOCK: return PAT_BLOCK;
      KIND_LEFT:  return PAT_LEFT;
      default:    return PAT_RIGHT;
    endcase
  endfunction
endpackage

// File: rtl/bmc_frame_seq.sv
module bmc_frame_seq
  import bmc_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192,
  parameter int CELL_W = $clog2(FRAME_CELLS)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  output logic [CELL_W-1:0] cell_idx,
  output logic              block_first,
  output logic              ready
);
  localparam int FRM_W = (FRAMES_PER_BLOCK > 1) ? $clog2(FRAMES_PER_BLOCK) : 1;
  localparam logic [CELL_W-1:0] LAST_CELL = CELL_W'(FRAME_CELLS - 1);
  localparam logic [FRM_W-1:0]  LAST_FRM  = FRM_W'(FRAMES_PER_BLOCK - 1);

  logic [FRM_W-1:0] frm_q;

  // cell_idx names the next cell to be sent
  always_ff @(posedge clk) begin
    if (rst) begin
      cell_idx <= '0;
      frm_q    <= '0;
      ready    <= 1'b1;
    end else if (tick) begin
      cell_idx <= cell_idx + CELL_W'(1);
      ready    <= (cell_idx == LAST_CELL);
      if (cell_idx == LAST_CELL)
        frm_q <= (frm_q == LAST_FRM) ? '0 : frm_q + FRM_W'(1);
    end
  end

  assign block_first = (frm_q == '0);
endmodule

// File: rtl/bmc_subframe_fmt.sv
module bmc_subframe_fmt
  import bmc_pkg::*;
#(
  parameter int SAMPLE_W = 16
)(
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                present,
  input  logic                mute_q,
  output logic [SLOTS-1:0]    word
);
  localparam int SAMPLE_LO = SLOT_VALID - SAMPLE_W;

  logic [SLOTS-1:0] body;

  always_comb begin
    body = '0;
    if (present) body[SAMPLE_LO +: SAMPLE_W] = sample;
    body[SLOT_VALID] = mute_q;
    body[SLOT_PAR]   = 1'b0;
    word = body;
    // spare slot absorbs the parity of everything else
    word[SLOT_BAL] = ^body;
  end
endmodule

// File: rtl/bmc_cell_enc.sv
module bmc_cell_enc
  import bmc_pkg::*;
#(
  parameter int SUB_W = $clog2(SUB_CELLS)
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [SUB_W-1:0]     sub_cell,
  input  logic [PRE_CELLS-1:0] pre_bits,
  input  logic [SLOTS-1:0]     word,
  output logic                 line
);
  localparam int PRE_IW = $clog2(PRE_CELLS);

  logic              ref_q;
  logic              ref_lvl;
  logic              bit_v;
  logic              nxt;
  logic [SUB_W-2:0]  slot;
  logic [PRE_IW-1:0] pidx;

  assign slot = sub_cell[SUB_W-1:1];
  assign pidx = PRE_IW'(PRE_CELLS - 1) - sub_cell[PRE_IW-1:0];

  always_comb begin
    ref_lvl = (sub_cell == '0) ? line : ref_q;
    bit_v   = word[slot];
    if (sub_cell < SUB_W'(PRE_CELLS))
      nxt = pre_bits[pidx] ^ ref_lvl;
    else if (!sub_cell[0])
      nxt = ~line;
    else
      nxt = bit_v ? ~line : line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line  <= 1'b0;
      ref_q <= 1'b0;
    end else if (tick) begin
      line <= nxt;
      if (sub_cell == '0) ref_q <= line;
    end
  end
endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
  import bmc_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int FRAMES_PER_BLOCK = 192
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                cell_tick,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                mute,
  output logic                line_out
);
  localparam int CELL_W = $clog2(FRAME_CELLS);
  localparam int SUB_W  = $clog2(SUB_CELLS);

  logic [CELL_W-1:0]    cell_idx;
  logic                 block_first;
  logic                 take;
  logic                 have_q;
  logic                 mute_q;
  logic [SAMPLE_W-1:0]  in_smp    [CHANNELS];
  logic [SLOTS-1:0]     slot_word [CHANNELS];
  logic                 right_half;
  pre_kind_e            kind;
  logic [PRE_CELLS-1:0] pre_bits;
  logic [SLOTS-1:0]     cur_word;

  assign in_smp[0] = smp_left;
  assign in_smp[1] = smp_right;
  assign take = cell_tick && smp_ready;

  bmc_frame_seq #(
    .FRAMES_PER_BLOCK(FRAMES_PER_BLOCK),
    .CELL_W(CELL_W)
  ) u_seq (
    .clk(clk),
    .rst(rst),
    .tick(cell_tick),
    .cell_idx(cell_idx),
    .block_first(block_first),
    .ready(smp_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q <= 1'b0;
      mute_q <= 1'b0;
    end else if (take) begin
      have_q <= smp_valid;
      mute_q <= mute;
    end
  end

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [SAMPLE_W-1:0] hold_q;

    always_ff @(posedge clk) begin
      if (rst)       hold_q <= '0;
      else if (take) hold_q <= in_smp[ch];
    end

    bmc_subframe_fmt #(.SAMPLE_W(SAMPLE_W)) u_fmt (
      .sample(hold_q),
      .present(have_q),
      .mute_q(mute_q),
      .word(slot_word[ch])
    );
  end

  assign right_half = cell_idx[CELL_W-1];

  always_comb begin
    if (right_half)       kind = KIND_RIGHT;
    else if (block_first) kind = KIND_BLOCK;
    else                  kind = KIND_LEFT;
  end

  assign pre_bits = pre_pattern(kind);
  assign cur_word = right_half ? slot_word[1] : slot_word[0];

  bmc_cell_enc #(.SUB_W(SUB_W)) u_enc (
    .clk(clk),
    .rst(rst),
    .tick(cell_tick),
    .sub_cell(cell_idx[SUB_W-1:0]),
    .pre_bits(pre_bits),
    .word(cur_word),
    .line(line_out)
  );
endmodule

// File: rtl/bmc_audio_tx_chk.sv
module bmc_audio_tx_chk
  import bmc_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic cell_tick,
  input logic smp_ready,
  input logic line_out
);
  localparam int CW = $clog2(FRAME_CELLS);
  localparam int SW = $clog2(SUB_CELLS);

  logic [CW-1:0] cc;
  logic [SW-1:0] sc;
  logic          started;

  assign sc = cc[SW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cc      <= '0;
      started <= 1'b0;
    end else if (cell_tick) begin
      cc      <= cc + CW'(1);
      started <= 1'b1;
    end
  end

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
    !started |-> (line_out == 1'b0));

  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (rst)
    !cell_tick |=> $stable(line_out));

  assert_preamble_lead_R3: assert property (@(posedge clk) disable iff (rst)
    (cell_tick && sc == '0) |=> (line_out != $past(line_out)));

  assert_preamble_run_R3: assert property (@(posedge clk) disable iff (rst)
    (cell_tick && (sc == SW'(1) || sc == SW'(2))) |=> $stable(line_out));

  assert_slot_edge_R5: assert property (@(posedge clk) disable iff (rst)
    (cell_tick && sc >= SW'(PRE_CELLS) && !sc[0]) |=> (line_out != $past(line_out)));

  assert_parity_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (cell_tick && sc == SW'(SUB_CELLS - 1)) |=> $stable(line_out));

  assert_ready_at_frame_R10: assert property (@(posedge clk) disable iff (rst)
    smp_ready == (cc == '0));
endmodule

bind bmc_audio_tx bmc_audio_tx_chk u_chk (
  .clk(clk),
  .rst(rst),
  .cell_tick(cell_tick),
  .smp_ready(smp_ready),
  .line_out(line_out)
);

// File: tb/tb_bmc_audio_tx.sv
`timescale 1ns/1ps
module tb_bmc_audio_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cell_tick = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_left = '0;
  logic [15:0] smp_right = '0;
  logic        mute = 1'b0;
  logic        line_out;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  bit    exp_bits[$];
  string exp_tags[$];
  bit    mlvl = 1'b0;
  int    frame_no = 0;
  logic  tick_q = 1'b0;
  logic  prev_line = 1'b0;

  always #2.5 clk = ~clk;

  bmc_audio_tx dut (
    .clk(clk), .rst(rst), .cell_tick(cell_tick), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right),
    .mute(mute), .line_out(line_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_cell(input bit v, input string tag);
    exp_bits.push_back(v);
    exp_tags.push_back(tag);
    mlvl = v;
  endtask

  // model of one subframe from the requirements
  task automatic model_sub(input bit [7:0] pat, input string ptag, input bit have,
                           input bit [15:0] s, input bit m, input string over);
    bit [31:0] w;
    bit        r;
    bit        c1;
    string     t;
    w = '0;
    if (have) w[27:12] = s;      // R6 sample slots
    w[28] = m;                   // R8 validity slot
    w[4]  = ^w;                  // R7 balance slot
    r = mlvl;
    for (int k = 7; k >= 0; k--) push_cell(pat[k] ^ r, ptag);   // R3
    for (int sl = 4; sl < 32; sl++) begin
      if (over != "")                  t = over;
      else if (sl == 4)                t = "R7";
      else if (sl == 28)               t = "R8";
      else if (sl >= 12 && sl <= 27)   t = have ? "R6" : "R9";
      else                             t = "R6";
      c1 = !mlvl;
      push_cell(c1, (over != "") ? over : "R5");
      push_cell(w[sl] ? !c1 : c1, t);
    end
  endtask

  task automatic send_frame(input bit pv, input bit [15:0] l, input bit [15:0] r,
                            input bit m, input bit nv, input bit [15:0] nl,
                            input bit [15:0] nr, input bit nm, input int gap,
                            input string over);
    bit    blk;
    blk = (frame_no % 192) == 0;
    model_sub(blk ? 8'b11101000 : 8'b11100010, blk ? "R4" : "R3", pv, l, m, over);
    model_sub(8'b11100100, "R3", pv, r, m, over);
    frame_no++;
    smp_valid = pv; smp_left = l; smp_right = r; mute = m;
    for (int c = 0; c < 128; c++) begin
      check(smp_ready === (c == 0), "R10", "ready before tick", {31'd0, smp_ready}, (c == 0));
      cell_tick = 1'b1;
      @(negedge clk);
      cell_tick = 1'b0;
      if (c == 0) begin
        smp_valid = nv; smp_left = nl; smp_right = nr; mute = nm;
      end
      repeat (gap) @(negedge clk);
    end
  endtask

  // monitor: a cell is due at the falling edge after the tick edge
  always @(posedge clk) tick_q <= cell_tick;

  always @(negedge clk) begin
    if (!rst) begin
      if (tick_q) begin
        if (exp_bits.size() == 0) begin
          check(1'b0, "R2", "unexpected cell", {31'd0, line_out}, 32'd0);
        end else begin
          bit    e;
          string tg;
          e  = exp_bits.pop_front();
          tg = exp_tags.pop_front();
          check(line_out === e, tg, "line cell", {31'd0, line_out}, {31'd0, e});
        end
      end else begin
        check(line_out === prev_line, "R2", "hold between ticks",
              {31'd0, line_out}, {31'd0, prev_line});
      end
      prev_line = line_out;
    end
  end

  initial begin
    #750000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: idle after reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(line_out === 1'b0, "R1", "idle line", {31'd0, line_out}, 32'd0);
      check(smp_ready === 1'b1, "R1", "idle ready", {31'd0, smp_ready}, 32'd1);
    end
    // frame 0: block start, plain data
    send_frame(1, 16'h0001, 16'h8000, 0, 0, 16'h0, 16'h0, 0, 0, "");
    // frame 1: nothing offered (R9)
    send_frame(0, 16'hFFFF, 16'hFFFF, 0, 0, 16'h0, 16'h0, 0, 0, "");
    // frame 2: muted, with tick gaps (R8)
    send_frame(1, 16'hA5C3, 16'h7FFF, 1, 0, 16'h0, 16'h0, 0, 1, "");
    // frame 3: new pair and mute offered mid-frame must wait (R10)
    send_frame(1, 16'h1234, 16'hFFFF, 0, 1, 16'hDEAD, 16'hBEEF, 1, 0, "R10");
    send_frame(1, 16'hDEAD, 16'hBEEF, 1, 0, 16'h0, 16'h0, 0, 0, "");
    // frames 5..193: crosses the block wrap at frame 192 (R4)
    for (int f = 5; f < 194; f++) begin
      bit [15:0] a;
      bit [15:0] b;
      a = 16'(f * 16'h3131) ^ 16'h5A0F;
      b = 16'(f * 16'h0F1D) + 16'h8001;
      send_frame((f % 5) != 0, a, b, (f % 7) == 0, 0, 16'h0, 16'h0, 0,
                 ((f % 4) == 0) ? 1 : 0, "");
    end
    repeat (3) @(negedge clk);
    check(exp_bits.size() == 0, "R2", "all cells sent", exp_bits.size(), 32'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule